// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Arbiter

This block gathers interrupt requests from two kinds of source and decides whether the core must be interrupted, at which priority level, and on behalf of which source. Seven asynchronous, active-low external request lines each carry a fixed level equal to their index. A configurable number of internal modules each present a request flag and a 3-bit level. Source 0 is the external-line source as a whole. Sources 1 to N are the internal modules.

A 3-bit mask, loaded from bits 10:8 of a status-word write, hides every level at or below its value. The top level is the exception and is never hidden. Each source owns a 4-bit arbitration number, writable through a small configuration port. When several sources request at the winning level, the larger arbitration number wins. A source whose number is zero is never selected. Duplicate nonzero numbers raise an error flag, and the lower source index then wins.

The core pulses an acknowledge. On the next cycle the block presents the level and source it granted for exactly one cycle. The pending flag follows whatever unmasked requests remain.

Top module: `irq_arbiter`

## Requirements
- R1: External lines pass through a two-flop synchronizer. Bit k of `irq_line_n` is line level k+1, and a low value means asserted. When several external lines are asserted, the external source presents the highest asserted level.
- R2: A level from 1 to 6 is recognized only when it is strictly greater than the current mask.
- R3: The mask resets to 7. A cycle with `sr_we` high loads the mask from `sr_wdata[10:8]` on the next edge, and the other bits of `sr_wdata` are ignored. `cur_mask` shows the mask.
- R4: Level 7 is recognized whatever the mask holds, including a mask of 7.
- R5: External level 7 is edge-sensitive. A transition of line 7 into the asserted state raises one level-7 request. That request stays until it is acknowledged, and holding the line low does not raise it again.
- R6: `pend_lvl` is the highest recognized level among all eligible sources. An internal module requests only when its `int_req` bit is high and its level field, `int_lvl[3m+2:3m]` for module m, is nonzero.
- R7: Among eligible sources at the winning level, the larger arbitration number wins. `pend_src` gives the winner's index: 0 for the external source, m+1 for internal module m.
- R8: Arbitration numbers reset to 4'hF for source 0 and to 0 for every internal module. A source whose number is 0 is never selected. A write with `arb_we` high sets the number of source `arb_sel` to `arb_wdata`.
- R9: `arb_conflict` is high exactly while two sources hold the same nonzero arbitration number. In that tie the lower source index wins.
- R10: When `ack` is high while `irq_pend` is high, the next cycle shows `ack_valid` high for one cycle, with `ack_lvl` and `ack_src` equal to the level and source pending at the acknowledge. An `ack` with nothing pending leaves `ack_valid` low.
- R11: `irq_pend` is high while any recognized request remains after an acknowledge. Acknowledging a level-7 grant to source 0 clears only the latched edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line_n | input | 7 | External request lines, bit k is level k+1, active low |
| int_req | input | N_INT | Internal module request flags |
| int_lvl | input | 3*N_INT | Internal module levels, 3 bits per module |
| sr_we | input | 1 | Status-word write strobe |
| sr_wdata | input | 16 | Status word, mask taken from bits 10:8 |
| arb_we | input | 1 | Arbitration number write strobe |
| arb_sel | input | SRC_W | Source index for the arbitration write |
| arb_wdata | input | 4 | New arbitration number |
| ack | input | 1 | Interrupt acknowledge from the core |
| cur_mask | output | 3 | Current mask value |
| irq_pend | output | 1 | A recognized request is pending |
| pend_lvl | output | 3 | Level of the winning request |
| pend_src | output | SRC_W | Index of the winning source |
| ack_valid | output | 1 | One-cycle grant strobe after an acknowledge |
| ack_lvl | output | 3 | Granted level |
| ack_src | output | SRC_W | Granted source |
| arb_conflict | output | 1 | Two sources share a nonzero arbitration number |

## Verification
The bench builds the block with the default N_INT of 3. That gives four sources and a 2-bit source index. With four sources, a level tie between the external source and a module, a tie between two modules with different numbers, and a duplicated number can all be set up at once. A vector table sweeps mask values against mixed external and internal patterns. Directed sequences then cover the reset values, a zero arbitration number, the single-shot behaviour of level 7 under a mask of 7, and acknowledges given both with and without a pending request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W = 3;
    localparam int ARB_W = 4;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [ARB_W-1:0] arb_t;
    localparam lvl_t LVL_TOP     = 3'd7;
    localparam arb_t ARB_EXT_RST = 4'hF;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   W       = 7,
    parameter int   STAGES  = 2,
    parameter logic RST_BIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES*W){RST_BIT}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_arb_pkg::*;
#(
    parameter int N = 6
) (
    input  logic [N-1:0] act,
    output lvl_t         lvl
);
    always_comb begin
        lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (act[i]) lvl = lvl_t'(i + 1);
        end
    end
endmodule

// File: rtl/irq_winner.sv
module irq_winner
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int SRC_W = 2
) (
    input  logic [N_SRC-1:0][LVL_W-1:0] src_lvl,
    input  logic [N_SRC-1:0][ARB_W-1:0] src_arb,
    input  lvl_t                        mask,
    output logic                        any,
    output lvl_t                        win_lvl,
    output logic [SRC_W-1:0]            win_src,
    output logic                        conflict
);
    logic [N_SRC-1:0] elig;
    arb_t             best_arb;

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            elig[i] = (src_arb[i] != '0) && (src_lvl[i] != '0) &&
                      ((src_lvl[i] == LVL_TOP) || (src_lvl[i] > mask));
        end
    end

    // Single pass: a later source replaces the current best only when it is
    // strictly better, so ties keep the lower index.
    always_comb begin
        any      = 1'b0;
        win_lvl  = '0;
        best_arb = '0;
        win_src  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && ((src_lvl[i] > win_lvl) ||
                            ((src_lvl[i] == win_lvl) && (src_arb[i] > best_arb)))) begin
                any      = 1'b1;
                win_lvl  = src_lvl[i];
                best_arb = src_arb[i];
                win_src  = SRC_W'(i);
            end
        end
    end

    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            for (int j = i + 1; j < N_SRC; j++) begin
                if ((src_arb[i] != '0) && (src_arb[i] == src_arb[j])) conflict = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_INT    = 3,
    parameter int N_EXT    = 7,
    parameter int SYNC_STG = 2,
    localparam int N_SRC   = N_INT + 1,
    localparam int SRC_W   = $clog2(N_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EXT-1:0]   irq_line_n,
    input  logic [N_INT-1:0]   int_req,
    input  logic [3*N_INT-1:0] int_lvl,
    input  logic               sr_we,
    input  logic [15:0]        sr_wdata,
    input  logic               arb_we,
    input  logic [SRC_W-1:0]   arb_sel,
    input  logic [3:0]         arb_wdata,
    input  logic               ack,
    output logic [2:0]         cur_mask,
    output logic               irq_pend,
    output logic [2:0]         pend_lvl,
    output logic [SRC_W-1:0]   pend_src,
    output logic               ack_valid,
    output logic [2:0]         ack_lvl,
    output logic [SRC_W-1:0]   ack_src,
    output logic               arb_conflict
);
    localparam int TOP_IDX = N_EXT - 1;
    localparam logic [N_SRC-1:0][ARB_W-1:0] ARB_RST = (N_SRC*ARB_W)'(ARB_EXT_RST);

    typedef struct packed {
        lvl_t                        mask;
        logic                        top_req;
        logic                        top_prev;
        logic [N_SRC-1:0][ARB_W-1:0] arb;
        logic                        ack_v;
        lvl_t                        ack_lvl;
        logic [SRC_W-1:0]            ack_src;
    } st_t;

    st_t st_d, st_q;

    logic [N_EXT-1:0] line_s_n;
    logic [N_EXT-1:0] line_act;
    lvl_t             low_lvl;
    lvl_t             ext_lvl;
    logic             top_edge;
    logic             top_clr;
    logic             win_any;
    lvl_t             win_lvl;
    logic [SRC_W-1:0] win_src;
    logic             conflict;
    logic [N_SRC-1:0][LVL_W-1:0] src_lvl;

    irq_sync #(.W(N_EXT), .STAGES(SYNC_STG), .RST_BIT(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_line_n),
        .q     (line_s_n)
    );

    assign line_act = ~line_s_n;

    irq_prio_enc #(.N(N_EXT-1)) i_enc (
        .act (line_act[N_EXT-2:0]),
        .lvl (low_lvl)
    );

    assign top_edge = line_act[TOP_IDX] & ~st_q.top_prev;
    assign ext_lvl  = st_q.top_req ? LVL_TOP : low_lvl;

    always_comb begin
        src_lvl[0] = ext_lvl;
        for (int m = 0; m < N_INT; m++) begin
            src_lvl[m+1] = int_req[m] ? int_lvl[3*m +: 3] : 3'd0;
        end
    end

    irq_winner #(.N_SRC(N_SRC), .SRC_W(SRC_W)) i_win (
        .src_lvl  (src_lvl),
        .src_arb  (st_q.arb),
        .mask     (st_q.mask),
        .any      (win_any),
        .win_lvl  (win_lvl),
        .win_src  (win_src),
        .conflict (conflict)
    );

    assign top_clr = ack && win_any && (win_lvl == LVL_TOP) && (win_src == '0);

    always_comb begin
        st_d          = st_q;
        st_d.top_prev = line_act[TOP_IDX];
        st_d.top_req  = (st_q.top_req && !top_clr) || top_edge;
        if (sr_we) st_d.mask = sr_wdata[10:8];
        if (arb_we && (int'(arb_sel) < N_SRC)) st_d.arb[arb_sel] = arb_wdata;
        st_d.ack_v    = ack && win_any;
        st_d.ack_lvl  = (ack && win_any) ? win_lvl : '0;
        st_d.ack_src  = (ack && win_any) ? win_src : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mask     <= LVL_TOP;
            st_q.arb      <= ARB_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_mask     = st_q.mask;
    assign irq_pend     = win_any;
    assign pend_lvl     = win_lvl;
    assign pend_src     = win_src;
    assign ack_valid    = st_q.ack_v;
    assign ack_lvl      = st_q.ack_lvl;
    assign ack_src      = st_q.ack_src;
    assign arb_conflict = conflict;

    // R2 / R4: a pending level is above the mask unless it is the top level
    a_r2_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> ((pend_lvl > cur_mask) || (pend_lvl == LVL_TOP)));

    // R3: a status-word write loads the mask from bits 10:8
    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> (cur_mask == $past(sr_wdata[10:8])));

    // R8: the selected source never holds a zero arbitration number
    a_r8_winner_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> (st_q.arb[pend_src] != '0));

    // R10: a grant strobe follows an acknowledge of a pending request
    a_r10_grant_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ($past(ack) && $past(irq_pend)));

    // R10: the grant reports the level that was pending at the acknowledge
    a_r10_grant_level: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_lvl == $past(pend_lvl)));

    // R5: an acknowledged latched top request is gone on the next cycle
    a_r5_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (top_clr && !top_edge) |=> !st_q.top_req);
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N_INT = 3;
    localparam int SRC_W = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [6:0]         irq_line_n = 7'h7F;
    logic [N_INT-1:0]   int_req = '0;
    logic [3*N_INT-1:0] int_lvl = '0;
    logic               sr_we = 1'b0;
    logic [15:0]        sr_wdata = '0;
    logic               arb_we = 1'b0;
    logic [SRC_W-1:0]   arb_sel = '0;
    logic [3:0]         arb_wdata = '0;
    logic               ack = 1'b0;
    logic [2:0]         cur_mask;
    logic               irq_pend;
    logic [2:0]         pend_lvl;
    logic [SRC_W-1:0]   pend_src;
    logic               ack_valid;
    logic [2:0]         ack_lvl;
    logic [SRC_W-1:0]   ack_src;
    logic               arb_conflict;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter #(.N_INT(N_INT)) i_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_line_n(irq_line_n), .int_req(int_req),
        .int_lvl(int_lvl), .sr_we(sr_we), .sr_wdata(sr_wdata), .arb_we(arb_we),
        .arb_sel(arb_sel), .arb_wdata(arb_wdata), .ack(ack), .cur_mask(cur_mask),
        .irq_pend(irq_pend), .pend_lvl(pend_lvl), .pend_src(pend_src),
        .ack_valid(ack_valid), .ack_lvl(ack_lvl), .ack_src(ack_src),
        .arb_conflict(arb_conflict)
    );

    typedef struct packed {
        logic [2:0] mask;
        logic [6:0] lines_n;
        logic [2:0] req;
        logic [2:0] l1;
        logic [2:0] l2;
        logic [2:0] l3;
        logic       pend;
        logic [2:0] lvl;
        logic [1:0] src;
    } vec_t;

    localparam int NV = 11;
    // numbers in use during the table: source0=F, source1=5, source2=9, source3=3
    localparam vec_t VECS [NV] = '{
        '{3'd0, 7'h7F, 3'b000, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0},
        '{3'd0, 7'h7B, 3'b000, 3'd0, 3'd0, 3'd0, 1'b1, 3'd3, 2'd0},
        '{3'd3, 7'h7B, 3'b000, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0},
        '{3'd2, 7'h7B, 3'b001, 3'd3, 3'd0, 3'd0, 1'b1, 3'd3, 2'd0},
        '{3'd0, 7'h7F, 3'b011, 3'd4, 3'd4, 3'd0, 1'b1, 3'd4, 2'd2},
        '{3'd0, 7'h6F, 3'b011, 3'd6, 3'd2, 3'd0, 1'b1, 3'd6, 2'd1},
        '{3'd4, 7'h7D, 3'b100, 3'd0, 3'd0, 3'd5, 1'b1, 3'd5, 2'd3},
        '{3'd6, 7'h7F, 3'b001, 3'd6, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0},
        '{3'd0, 7'h7F, 3'b001, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0},
        '{3'd5, 7'h5B, 3'b000, 3'd0, 3'd0, 3'd0, 1'b1, 3'd6, 2'd0},
        '{3'd6, 7'h7F, 3'b010, 3'd0, 3'd7, 3'd0, 1'b1, 3'd7, 2'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic set_mask(input logic [2:0] m);
        @(negedge clk);
        sr_we = 1'b1;
        sr_wdata = {5'b10101, m, 8'hC3};
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic set_arb(input int sel, input logic [3:0] v);
        @(negedge clk);
        arb_we = 1'b1;
        arb_sel = SRC_W'(sel);
        arb_wdata = v;
        @(negedge clk);
        arb_we = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset values: R3 mask 7, R8 default numbers give no conflict
        chk("R3 reset mask", int'(cur_mask), 7);
        chk("R11 reset pend", int'(irq_pend), 0);
        chk("R10 reset ack_valid", int'(ack_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset conflict", int'(arb_conflict), 0);

        // R3: line 6 is hidden by the reset mask; R8: module with number 0 is never chosen
        irq_line_n = 7'h5F;
        int_req = 3'b001;
        int_lvl = {3'd0, 3'd0, 3'd7};
        settle();
        chk("R3 R8 masked and zero-number", int'(irq_pend), 0);
        irq_line_n = 7'h7F;
        int_req = '0;
        set_mask(3'd4);
        chk("R3 mask from bits 10:8", int'(cur_mask), 4);

        set_arb(1, 4'd5);
        set_arb(2, 4'd9);
        set_arb(3, 4'd3);
        chk("R9 distinct numbers", int'(arb_conflict), 0);

        // vector table: R1 R2 R6 R7 R11
        for (int k = 0; k < NV; k++) begin
            set_mask(VECS[k].mask);
            irq_line_n = VECS[k].lines_n;
            int_req = VECS[k].req;
            int_lvl = {VECS[k].l3, VECS[k].l2, VECS[k].l1};
            settle();
            chk($sformatf("R2 R11 vec%0d pend", k), int'(irq_pend), int'(VECS[k].pend));
            if (VECS[k].pend) begin
                chk($sformatf("R1 R6 vec%0d lvl", k), int'(pend_lvl), int'(VECS[k].lvl));
                chk($sformatf("R7 vec%0d src", k), int'(pend_src), int'(VECS[k].src));
            end
        end
        int_req = '0;
        irq_line_n = 7'h7F;

        // R4 R5: top level under mask 7, single shot while held low
        set_mask(3'd7);
        irq_line_n = 7'h3F;
        settle();
        chk("R4 top level under mask 7", int'(irq_pend), 1);
        chk("R4 top level value", int'(pend_lvl), 7);
        chk("R1 top level source", int'(pend_src), 0);
        pulse_ack();
        chk("R10 grant strobe", int'(ack_valid), 1);
        chk("R10 grant level", int'(ack_lvl), 7);
        chk("R10 grant source", int'(ack_src), 0);
        @(negedge clk);
        chk("R10 strobe one cycle", int'(ack_valid), 0);
        chk("R5 held low raises once", int'(irq_pend), 0);
        settle();
        chk("R5 still held low", int'(irq_pend), 0);
        irq_line_n = 7'h7F;
        settle();
        irq_line_n = 7'h3F;
        settle();
        chk("R5 new falling edge", int'(irq_pend), 1);
        irq_line_n = 7'h7F;
        settle();
        chk("R5 latched after release", int'(irq_pend), 1);
        pulse_ack();
        @(negedge clk);
        chk("R5 cleared by ack", int'(irq_pend), 0);

        // R11: pending survives an acknowledge while requests remain
        set_mask(3'd0);
        irq_line_n = 7'h7B;
        int_req = 3'b001;
        int_lvl = {3'd0, 3'd0, 3'd6};
        settle();
        pulse_ack();
        chk("R10 grant level module", int'(ack_lvl), 6);
        chk("R10 grant source module", int'(ack_src), 1);
        chk("R11 still pending", int'(irq_pend), 1);
        chk("R11 still level 6", int'(pend_lvl), 6);
        int_req = '0;
        @(negedge clk);
        chk("R11 falls to line 3", int'(pend_lvl), 3);
        chk("R11 line 3 source", int'(pend_src), 0);

        // R10: acknowledge with nothing pending
        irq_line_n = 7'h7F;
        settle();
        pulse_ack();
        chk("R10 no grant when idle", int'(ack_valid), 0);

        // R9: duplicated number, lower index wins
        set_arb(3, 4'd9);
        chk("R9 conflict raised", int'(arb_conflict), 1);
        int_req = 3'b110;
        int_lvl = {3'd4, 3'd4, 3'd0};
        @(negedge clk);
        chk("R9 lower index wins", int'(pend_src), 2);
        set_arb(3, 4'd3);
        chk("R9 conflict cleared", int'(arb_conflict), 0);
        chk("R7 higher number wins", int'(pend_src), 2);
        set_arb(2, 4'd0);
        chk("R8 zero number drops out", int'(pend_src), 3);
        int_req = '0;

        finish_run();
    end
endmodule